// File: doc/BRIEF.md
# Multi-Cycle Load/Store Control Sequencer

This block is the control state machine for a small 16-bit load/store processor with eight general registers. Register 7 is the program counter and is written like any other entry of the register file, so the PC increment, the branch target and the address arithmetic all pass through the shared ALU. The sequencer owns the instruction register and latches it from the host read bus during the second fetch cycle. It then steps through one of several short execution sequences. On every cycle it drives register-file selects, the ALU function, an immediate operand, status-word controls and the memory strobes toward an external host that supplies memory.

Every output is decoded from two registers only: the state register and the instruction register. The one exception is the branch write enable, which also follows the `cond_ok` flag that the status logic evaluates. Reset is synchronous and active-high.

Major opcode assignments: `000` branch/control, `001` register arithmetic, `010` address generate, `011` reserved, `100` byte load, `101` word load, `110` byte store, `111` word store. Bit 13 therefore selects the access size for loads and stores.

Top module: `rsq_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the machine enters an idle wait state. In that state `mem_rd`, `mem_wr`, `wr_en`, `ps_wr`, `ir_load`, `halt_o` and `bus_out_en` are low, and `alu_op` is ADD (`5'h10`).
- R2: On the first edge with `rst` low, the machine leaves the wait state. It spends one cycle writing the reset PC value (0) into register 7 through ALU PASS_B (`5'h12`) with `b_from_imm`, and then begins a fetch.
- R3: A fetch takes two cycles. The first cycle reads register 7, drives it out with ALU PASS_A (`5'h11`), and raises `mem_rd`, `mem_word` and `bus_out_en`. The second cycle raises `ir_load`, captures `mem_rdata` as the instruction, and writes register 7 with register 7 plus an immediate of 2 (ADD).
- R4: Instruction fields are major opcode [15:13], A [12:10], D [9:7], B [6:4] and minor [3:0]. Arithmetic (major `001`) reads A and B, writes D, raises `cc_upd`, and presents `alu_op = {1'b0, minor}`.
- R5: Major `000` with a nonzero `{ir[12:10], ir[0]}` is a branch. It adds the word displacement `ir[9:1]`, sign-extended and shifted left by one, to register 7. It writes register 7 only when `cond_ok` is high, and presents the 4-bit condition on `br_cond`.
- R6: Address generate (major `010`) writes D with A plus the sign-extended 7-bit offset `ir[6:0]` in a single cycle.
- R7: A load first spends one cycle driving A plus the sign-extended offset with `mem_rd`, `bus_out_en`, and `mem_word = ir[13]`. It then spends one cycle writing D from memory, with `wr_from_mem` high.
- R8: A load whose base is register 7 and whose offset is zero takes a third cycle. That cycle writes register 7 with register 7 plus 2, skipping the inline operand. Any other load returns to fetch after two cycles.
- R9: A store spends one cycle driving its address with `mem_wr` and `mem_word = ir[13]`. It then spends one cycle driving D out through PASS_B with `bus_out_en` and no strobe.
- R10: When bits [15:10] and bit 0 are zero, bits [2:1] select a control operation. `11` writes D from the status word (`a_from_ps`, PASS_A). `10` loads the status word from B (`ps_wr`, PASS_B).
- R11: Control code `00` is a one-cycle halt. It drives B out through PASS_B with `halt_o` and `bus_out_en`, and is followed directly by a fetch.
- R12: Control code `01` is a four-cycle return. The cycles are: read at address `FFFC`; write register 7 from memory; read at `FFFE`; load the status word from memory (`ps_wr` with `wr_from_mem`).
- R13: The reserved major opcode `011` behaves exactly like a halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 16 | Host read data; sampled as the instruction in fetch cycle 2 |
| cond_ok | input | 1 | Branch condition result from the status logic |
| rd_a_sel | output | 3 | Register file read port A select |
| rd_b_sel | output | 3 | Register file read port B select |
| wr_sel | output | 3 | Register file write select |
| wr_en | output | 1 | Register file write enable (register 7 = PC update) |
| wr_from_mem | output | 1 | Write data taken from host read bus instead of ALU |
| a_from_ps | output | 1 | ALU operand A taken from the status word |
| b_from_imm | output | 1 | ALU operand B taken from `imm` |
| imm | output | 16 | Immediate operand for ALU input B |
| alu_op | output | 5 | ALU function: `{0,minor}` or ADD/PASS_A/PASS_B |
| cc_upd | output | 1 | Update condition codes from the ALU result |
| ps_wr | output | 1 | Load the status word |
| ir_load | output | 1 | Instruction register latch strobe |
| br_cond | output | 4 | Branch condition code during a branch cycle |
| mem_rd | output | 1 | Host memory read request |
| mem_wr | output | 1 | Host memory write request |
| mem_word | output | 1 | Word (1) or byte (0) access |
| bus_out_en | output | 1 | ALU result drives the host address/data bus |
| halt_o | output | 1 | Halt indication to the host |

## Verification
A wrong state register shows at the ports in the very next cycle. Each state has a distinct pattern of strobes, selects and immediates, so a skipped cycle, such as a missing PC-skip cycle or a shortened return, puts a strobe in the wrong cycle at once. A wrong instruction capture, or a field taken from the wrong bits, shows in the first execution cycle as wrong register selects, the wrong offset on `imm`, or the wrong branch condition. The bench compares every output against a behavioural model on every clock, so such faults are caught within one cycle of their cause.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [4:0] {
    S_RST0, S_RST1, S_F1, S_F2, S_BCC, S_ARITH, S_LDA,
    S_LD1, S_LD2, S_LD3, S_ST1, S_ST2, S_RDPS, S_WRPS,
    S_HALT, S_IRT1, S_IRT2, S_IRT3, S_IRT4
  } seq_state_e;

  localparam logic [4:0] ALU_ADD    = 5'h10;
  localparam logic [4:0] ALU_PASS_A = 5'h11;
  localparam logic [4:0] ALU_PASS_B = 5'h12;

  localparam logic [2:0] MAJ_CTL   = 3'b000;
  localparam logic [2:0] MAJ_ARITH = 3'b001;
  localparam logic [2:0] MAJ_LDA   = 3'b010;

endpackage

// File: rtl/rsq_decode.sv
module rsq_decode
  import rsq_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic [IW-1:0] word,
  output seq_state_e    first_exec
);

  logic [2:0] major;
  logic [3:0] cond;

  assign major = word[15:13];
  assign cond  = {word[12:10], word[0]};

  always_comb begin
    first_exec = S_HALT;
    case (major)
      MAJ_CTL: begin
        if (cond != 4'd0) begin
          first_exec = S_BCC;
        end else begin
          case (word[2:1])
            2'b00:   first_exec = S_HALT;
            2'b01:   first_exec = S_IRT1;
            2'b10:   first_exec = S_WRPS;
            default: first_exec = S_RDPS;
          endcase
        end
      end
      MAJ_ARITH:     first_exec = S_ARITH;
      MAJ_LDA:       first_exec = S_LDA;
      3'b100, 3'b101: first_exec = S_LD1;
      3'b110, 3'b111: first_exec = S_ST1;
      default:       first_exec = S_HALT;
    endcase
  end

endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
  import rsq_pkg::*;
#(
  parameter int IW     = 16,
  parameter int RW     = 3,
  parameter int PC_IDX = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] mem_rdata,
  output seq_state_e    state_q,
  output logic [IW-1:0] ir_q
);

  localparam logic [RW-1:0] PC_SEL = RW'(PC_IDX);

  seq_state_e state_d;
  seq_state_e exec_entry;
  logic       pc_skip;

  rsq_decode #(.IW(IW)) u_decode (
    .word       (mem_rdata),
    .first_exec (exec_entry)
  );

  assign pc_skip = (ir_q[12:10] == PC_SEL) && (ir_q[6:0] == 7'd0);

  always_comb begin
    state_d = S_F1;
    case (state_q)
      S_RST0: state_d = S_RST1;
      S_RST1: state_d = S_F1;
      S_F1:   state_d = S_F2;
      S_F2:   state_d = exec_entry;
      S_LD1:  state_d = S_LD2;
      S_LD2:  state_d = pc_skip ? S_LD3 : S_F1;
      S_ST1:  state_d = S_ST2;
      S_IRT1: state_d = S_IRT2;
      S_IRT2: state_d = S_IRT3;
      S_IRT3: state_d = S_IRT4;
      default: state_d = S_F1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_RST0;
      ir_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_F2) ir_q <= mem_rdata;
    end
  end

endmodule

// File: rtl/rsq_outdec.sv
module rsq_outdec
  import rsq_pkg::*;
#(
  parameter int                IW     = 16,
  parameter int                RW     = 3,
  parameter int                PC_IDX = 7,
  parameter logic [IW-1:0]     RST_PC = '0,
  parameter logic [IW-1:0]     VEC_PC = 16'hFFFC,
  parameter logic [IW-1:0]     VEC_PS = 16'hFFFE
) (
  input  seq_state_e    state,
  input  logic [IW-1:0] ir,
  input  logic          cond_ok,
  output logic [RW-1:0] rd_a_sel,
  output logic [RW-1:0] rd_b_sel,
  output logic [RW-1:0] wr_sel,
  output logic          wr_en,
  output logic          wr_from_mem,
  output logic          a_from_ps,
  output logic          b_from_imm,
  output logic [IW-1:0] imm,
  output logic [4:0]    alu_op,
  output logic          cc_upd,
  output logic          ps_wr,
  output logic          ir_load,
  output logic [3:0]    br_cond,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          mem_word,
  output logic          bus_out_en,
  output logic          halt_o
);

  localparam logic [RW-1:0] PC_SEL  = RW'(PC_IDX);
  localparam logic [IW-1:0] PC_STEP = IW'(2);

  logic [RW-1:0] f_a, f_d, f_b;
  logic [IW-1:0] off_byte, off_word;

  assign f_a      = ir[12:10];
  assign f_d      = ir[9:7];
  assign f_b      = ir[6:4];
  assign off_byte = {{(IW-7){ir[6]}}, ir[6:0]};
  assign off_word = {{(IW-10){ir[9]}}, ir[9:1], 1'b0};

  always_comb begin
    rd_a_sel    = '0;
    rd_b_sel    = '0;
    wr_sel      = '0;
    wr_en       = 1'b0;
    wr_from_mem = 1'b0;
    a_from_ps   = 1'b0;
    b_from_imm  = 1'b0;
    imm         = '0;
    alu_op      = ALU_ADD;
    cc_upd      = 1'b0;
    ps_wr       = 1'b0;
    ir_load     = 1'b0;
    br_cond     = 4'd0;
    mem_rd      = 1'b0;
    mem_wr      = 1'b0;
    mem_word    = 1'b0;
    bus_out_en  = 1'b0;
    halt_o      = 1'b0;
    case (state)
      S_RST1: begin
        b_from_imm = 1'b1; imm = RST_PC; alu_op = ALU_PASS_B;
        wr_en = 1'b1; wr_sel = PC_SEL;
      end
      S_F1: begin
        rd_a_sel = PC_SEL; alu_op = ALU_PASS_A;
        mem_rd = 1'b1; mem_word = 1'b1; bus_out_en = 1'b1;
      end
      S_F2, S_LD3: begin
        ir_load  = (state == S_F2);
        rd_a_sel = PC_SEL; b_from_imm = 1'b1; imm = PC_STEP;
        wr_en = 1'b1; wr_sel = PC_SEL;
      end
      S_BCC: begin
        rd_a_sel = PC_SEL; b_from_imm = 1'b1; imm = off_word;
        br_cond  = {ir[12:10], ir[0]};
        wr_en = cond_ok; wr_sel = PC_SEL;
      end
      S_ARITH: begin
        rd_a_sel = f_a; rd_b_sel = f_b; alu_op = {1'b0, ir[3:0]};
        wr_en = 1'b1; wr_sel = f_d; cc_upd = 1'b1;
      end
      S_LDA: begin
        rd_a_sel = f_a; b_from_imm = 1'b1; imm = off_byte;
        wr_en = 1'b1; wr_sel = f_d;
      end
      S_LD1, S_ST1: begin
        rd_a_sel = f_a; b_from_imm = 1'b1; imm = off_byte;
        mem_rd = (state == S_LD1); mem_wr = (state == S_ST1);
        mem_word = ir[13]; bus_out_en = 1'b1;
      end
      S_LD2: begin
        wr_en = 1'b1; wr_sel = f_d; wr_from_mem = 1'b1;
      end
      S_ST2: begin
        rd_b_sel = f_d; alu_op = ALU_PASS_B;
        mem_word = ir[13]; bus_out_en = 1'b1;
      end
      S_RDPS: begin
        a_from_ps = 1'b1; alu_op = ALU_PASS_A;
        wr_en = 1'b1; wr_sel = f_d;
      end
      S_WRPS: begin
        rd_b_sel = f_b; alu_op = ALU_PASS_B; ps_wr = 1'b1;
      end
      S_HALT: begin
        rd_b_sel = f_b; alu_op = ALU_PASS_B;
        bus_out_en = 1'b1; halt_o = 1'b1;
      end
      S_IRT1, S_IRT3: begin
        b_from_imm = 1'b1; imm = (state == S_IRT1) ? VEC_PC : VEC_PS;
        alu_op = ALU_PASS_B; mem_rd = 1'b1; mem_word = 1'b1; bus_out_en = 1'b1;
      end
      S_IRT2: begin
        wr_en = 1'b1; wr_sel = PC_SEL; wr_from_mem = 1'b1;
      end
      S_IRT4: begin
        ps_wr = 1'b1; wr_from_mem = 1'b1;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/rsq_sequencer.sv
module rsq_sequencer
  import rsq_pkg::*;
#(
  parameter int            IW     = 16,
  parameter int            RW     = 3,
  parameter int            PC_IDX = 7,
  parameter logic [IW-1:0] RST_PC = '0,
  parameter logic [IW-1:0] VEC_PC = 16'hFFFC,
  parameter logic [IW-1:0] VEC_PS = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] mem_rdata,
  input  logic          cond_ok,
  output logic [RW-1:0] rd_a_sel,
  output logic [RW-1:0] rd_b_sel,
  output logic [RW-1:0] wr_sel,
  output logic          wr_en,
  output logic          wr_from_mem,
  output logic          a_from_ps,
  output logic          b_from_imm,
  output logic [IW-1:0] imm,
  output logic [4:0]    alu_op,
  output logic          cc_upd,
  output logic          ps_wr,
  output logic          ir_load,
  output logic [3:0]    br_cond,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          mem_word,
  output logic          bus_out_en,
  output logic          halt_o
);

  seq_state_e    state_q;
  logic [IW-1:0] ir_q;

  rsq_fsm #(.IW(IW), .RW(RW), .PC_IDX(PC_IDX)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .mem_rdata (mem_rdata),
    .state_q   (state_q),
    .ir_q      (ir_q)
  );

  rsq_outdec #(
    .IW(IW), .RW(RW), .PC_IDX(PC_IDX),
    .RST_PC(RST_PC), .VEC_PC(VEC_PC), .VEC_PS(VEC_PS)
  ) u_outdec (
    .state       (state_q),
    .ir          (ir_q),
    .cond_ok     (cond_ok),
    .rd_a_sel    (rd_a_sel),
    .rd_b_sel    (rd_b_sel),
    .wr_sel      (wr_sel),
    .wr_en       (wr_en),
    .wr_from_mem (wr_from_mem),
    .a_from_ps   (a_from_ps),
    .b_from_imm  (b_from_imm),
    .imm         (imm),
    .alu_op      (alu_op),
    .cc_upd      (cc_upd),
    .ps_wr       (ps_wr),
    .ir_load     (ir_load),
    .br_cond     (br_cond),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_word    (mem_word),
    .bus_out_en  (bus_out_en),
    .halt_o      (halt_o)
  );

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int IW     = 16,
  parameter int RW     = 3,
  parameter int PC_IDX = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          cond_ok,
  input logic [RW-1:0] rd_a_sel,
  input logic [RW-1:0] wr_sel,
  input logic          wr_en,
  input logic [IW-1:0] imm,
  input logic [4:0]    alu_op,
  input logic          cc_upd,
  input logic          ir_load,
  input logic [3:0]    br_cond,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_word,
  input logic          bus_out_en,
  input logic          halt_o
);

  localparam logic [RW-1:0] PC_SEL = RW'(PC_IDX);

  // R1 and R2: idle on the edge that sees reset released, then the PC clear cycle
  p_reset_exit_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!wr_en && !mem_rd && !mem_wr && !halt_o) ##1
                   (wr_en && wr_sel == PC_SEL && imm == '0));

  p_fetch_pair_r3: assert property (@(posedge clk) disable iff (rst)
    ir_load |-> $past(mem_rd && bus_out_en && rd_a_sel == PC_SEL));

  p_arith_cc_r4: assert property (@(posedge clk) disable iff (rst)
    cc_upd |-> (wr_en && !alu_op[4]));

  p_branch_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (br_cond != 4'd0 && !cond_ok) |-> !wr_en);

  p_store_data_r9: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> (bus_out_en && !mem_wr && !mem_rd && mem_word == $past(mem_word)));

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr, halt_o}));

  p_halt_resume_r11: assert property (@(posedge clk) disable iff (rst)
    halt_o |=> (mem_rd && rd_a_sel == PC_SEL));

endmodule

bind rsq_sequencer rsq_checker i_chk (
  .clk        (clk),
  .rst        (rst),
  .cond_ok    (cond_ok),
  .rd_a_sel   (rd_a_sel),
  .wr_sel     (wr_sel),
  .wr_en      (wr_en),
  .imm        (imm),
  .alu_op     (alu_op),
  .cc_upd     (cc_upd),
  .ir_load    (ir_load),
  .br_cond    (br_cond),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_word   (mem_word),
  .bus_out_en (bus_out_en),
  .halt_o     (halt_o)
);

// File: tb/test_rsq_sequencer.sv
module test_rsq_sequencer;

  localparam int CLK_PERIOD = 10;

  localparam int M_RST0 = 0,  M_RST1 = 1,  M_F1 = 2,    M_F2 = 3,    M_BCC = 4;
  localparam int M_ARI  = 5,  M_LDA  = 6,  M_LD1 = 7,   M_LD2 = 8,   M_LD3 = 9;
  localparam int M_ST1  = 10, M_ST2  = 11, M_RDPS = 12, M_WRPS = 13, M_HALT = 14;
  localparam int M_RT1  = 15, M_RT2  = 16, M_RT3 = 17,  M_RT4 = 18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cond_ok = 1'b0;
  logic [15:0] mem_rdata = 16'h0000;

  logic [2:0]  rd_a_sel, rd_b_sel, wr_sel;
  logic        wr_en, wr_from_mem, a_from_ps, b_from_imm;
  logic [15:0] imm;
  logic [4:0]  alu_op;
  logic        cc_upd, ps_wr, ir_load;
  logic [3:0]  br_cond;
  logic        mem_rd, mem_wr, mem_word, bus_out_en, halt_o;

  int          m_st = 0;
  logic [15:0] m_ir = 16'h0000;
  int          n_cmp = 0;
  int          n_bad = 0;
  int          pi = 0;
  logic [15:0] prog [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  rsq_sequencer i_rsq_sequencer (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .cond_ok(cond_ok),
    .rd_a_sel(rd_a_sel), .rd_b_sel(rd_b_sel), .wr_sel(wr_sel), .wr_en(wr_en),
    .wr_from_mem(wr_from_mem), .a_from_ps(a_from_ps), .b_from_imm(b_from_imm),
    .imm(imm), .alu_op(alu_op), .cc_upd(cc_upd), .ps_wr(ps_wr), .ir_load(ir_load),
    .br_cond(br_cond), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_word(mem_word),
    .bus_out_en(bus_out_en), .halt_o(halt_o)
  );

  function automatic int first_of(logic [15:0] w);
    if (w[15:14] == 2'b10) return M_LD1;
    if (w[15:14] == 2'b11) return M_ST1;
    if (w[15:13] == 3'b001) return M_ARI;
    if (w[15:13] == 3'b010) return M_LDA;
    if (w[15:13] == 3'b011) return M_HALT;
    if (w[12:10] != 3'd0 || w[0]) return M_BCC;
    if (w[2:1] == 2'b01) return M_RT1;
    if (w[2:1] == 2'b10) return M_WRPS;
    if (w[2:1] == 2'b11) return M_RDPS;
    return M_HALT;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st <= M_RST0;
      m_ir <= 16'h0000;
    end else begin
      if (m_st == M_F2) m_ir <= mem_rdata;
      if (m_st == M_RST0) m_st <= M_RST1;
      else if (m_st == M_F1) m_st <= M_F2;
      else if (m_st == M_F2) m_st <= first_of(mem_rdata);
      else if (m_st == M_LD1) m_st <= M_LD2;
      else if (m_st == M_LD2) m_st <= (m_ir[12:10] == 3'd7 && m_ir[6:0] == 7'd0) ? M_LD3 : M_F1;
      else if (m_st == M_ST1) m_st <= M_ST2;
      else if (m_st >= M_RT1 && m_st < M_RT4) m_st <= m_st + 1;
      else m_st <= M_F1;
    end
  end

  // packing: rda rdb wrs wen wfm aps bim imm[16] op[5] cc psw irl brc[4] rd wr wd bus hlt
  function automatic logic [45:0] expect_vec(int st, logic [15:0] ir, logic c);
    logic [2:0] ra = 0, rb = 0, ws = 0;
    logic we = 0, wm = 0, ap = 0, bi = 0, cc = 0, pw = 0, il = 0;
    logic [15:0] im = 0;
    logic [4:0] op = 5'h10;
    logic [3:0] bc = 0;
    logic r = 0, w = 0, wd = 0, bo = 0, h = 0;
    logic [15:0] sx7 = {{9{ir[6]}}, ir[6:0]};
    case (st)
      M_RST1: begin bi = 1; op = 5'h12; we = 1; ws = 7; end
      M_F1:   begin ra = 7; op = 5'h11; r = 1; wd = 1; bo = 1; end
      M_F2:   begin il = 1; ra = 7; bi = 1; im = 2; we = 1; ws = 7; end
      M_LD3:  begin ra = 7; bi = 1; im = 2; we = 1; ws = 7; end
      M_BCC:  begin ra = 7; bi = 1; im = {{6{ir[9]}}, ir[9:1], 1'b0};
                    bc = {ir[12:10], ir[0]}; we = c; ws = 7; end
      M_ARI:  begin ra = ir[12:10]; rb = ir[6:4]; op = {1'b0, ir[3:0]};
                    we = 1; ws = ir[9:7]; cc = 1; end
      M_LDA:  begin ra = ir[12:10]; bi = 1; im = sx7; we = 1; ws = ir[9:7]; end
      M_LD1:  begin ra = ir[12:10]; bi = 1; im = sx7; r = 1; wd = ir[13]; bo = 1; end
      M_ST1:  begin ra = ir[12:10]; bi = 1; im = sx7; w = 1; wd = ir[13]; bo = 1; end
      M_LD2:  begin we = 1; ws = ir[9:7]; wm = 1; end
      M_ST2:  begin rb = ir[9:7]; op = 5'h12; wd = ir[13]; bo = 1; end
      M_RDPS: begin ap = 1; op = 5'h11; we = 1; ws = ir[9:7]; end
      M_WRPS: begin rb = ir[6:4]; op = 5'h12; pw = 1; end
      M_HALT: begin rb = ir[6:4]; op = 5'h12; bo = 1; h = 1; end
      M_RT1:  begin bi = 1; im = 16'hFFFC; op = 5'h12; r = 1; wd = 1; bo = 1; end
      M_RT3:  begin bi = 1; im = 16'hFFFE; op = 5'h12; r = 1; wd = 1; bo = 1; end
      M_RT2:  begin we = 1; ws = 7; wm = 1; end
      M_RT4:  begin pw = 1; wm = 1; end
      default: begin end
    endcase
    return {ra, rb, ws, we, wm, ap, bi, im, op, cc, pw, il, bc, r, w, wd, bo, h};
  endfunction

  function automatic string tag_of(int st, logic [15:0] ir);
    case (st)
      M_RST0: return "R1";
      M_RST1: return "R2";
      M_F1, M_F2: return "R3";
      M_ARI:  return "R4";
      M_BCC:  return "R5";
      M_LDA:  return "R6";
      M_LD1, M_LD2: return "R7";
      M_LD3:  return "R8";
      M_ST1, M_ST2: return "R9";
      M_RDPS, M_WRPS: return "R10";
      M_HALT: return (ir[15:13] == 3'b011) ? "R13" : "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic step();
    logic [45:0] got, want;
    @(negedge clk);
    cond_ok = ~cond_ok;
    if (m_st == M_F2) begin
      mem_rdata = prog[pi % 16];
      pi++;
    end else begin
      mem_rdata = 16'h5A5A;
    end
    #1;
    got = {rd_a_sel, rd_b_sel, wr_sel, wr_en, wr_from_mem, a_from_ps, b_from_imm,
           imm, alu_op, cc_upd, ps_wr, ir_load, br_cond, mem_rd, mem_wr, mem_word,
           bus_out_en, halt_o};
    want = expect_vec(m_st, m_ir, cond_ok);
    n_cmp++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s state=%0d actual=%h expected=%h", tag_of(m_st, m_ir), m_st, got, want);
    end
  endtask

  initial begin
    prog[0]  = {3'b001, 3'd1, 3'd2, 3'd3, 4'd5};
    prog[1]  = {3'b000, 3'd2, 9'h1FD, 1'b0};
    prog[2]  = {3'b000, 3'd0, 9'd5, 1'b1};
    prog[3]  = {3'b010, 3'd4, 3'd5, 7'h7E};
    prog[4]  = {3'b101, 3'd2, 3'd6, 7'd10};
    prog[5]  = {3'b100, 3'd3, 3'd1, 7'h40};
    prog[6]  = {3'b101, 3'd7, 3'd4, 7'd0};
    prog[7]  = {3'b101, 3'd7, 3'd4, 7'd4};
    prog[8]  = {3'b111, 3'd1, 3'd2, 7'h7F};
    prog[9]  = {3'b110, 3'd6, 3'd3, 7'd3};
    prog[10] = {6'd0, 3'd5, 3'd0, 1'b0, 2'b11, 1'b0};
    prog[11] = {6'd0, 3'd0, 3'd6, 1'b0, 2'b10, 1'b0};
    prog[12] = {6'd0, 3'd0, 3'd0, 1'b1, 2'b01, 1'b0};
    prog[13] = {6'd0, 3'd0, 3'd4, 1'b0, 2'b00, 1'b0};
    prog[14] = {3'b011, 13'h0ABC};
    prog[15] = {3'b001, 3'd7, 3'd0, 3'd6, 4'd12};

    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    repeat (250) step();
    rst = 1'b1;
    repeat (2) step();
    rst = 1'b0;
    repeat (251) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule